// File: doc/BRIEF.md
# Toggle-Strobe Serial Word Transmitter

This block sends one parallel word at a time over a two-wire link: a data line that carries the word one bit per cycle, and a strobe line that changes level once for each frame. A frame may start on a rising strobe edge or on a falling one, so consecutive frames alternate between the two. Inside the block, a set/reset controller watches the strobe. Any strobe edge turns on a local bit-clock enable, and the rising edge of a stop signal turns it off. A bit counter produces that stop signal once the whole word has been shifted.

The free-running bit oscillator is modelled as a clock enable on the single system clock. Before each frame, the producer pulses a clear to re-arm the counter. It then raises a load request together with the word. An accepted load captures the word and flips the strobe. The bits then follow on the data line, least significant first, and a done flag pulses alongside the final bit.

Top module: `strobe_ser_tx`

## Requirements
- R1: After reset, `strb_o`, `ser_o` and `done_o` are all 0, and the block is armed, so a load request is accepted without a prior clear.
- R2: An accepted load flips `strb_o` exactly once, on the clock edge that samples the request. A load is accepted only while the block is armed and the bit clock is stopped.
- R3: The captured word appears on `ser_o` least significant bit first, over WORD_W consecutive cycles. The first bit is on the line two cycles after the strobe change. Changing `word_i` after acceptance has no effect on the frame.
- R4: `ser_o` is 0 in every cycle outside a frame's data window, including the cycle between the strobe change and the first bit.
- R5: `done_o` is high for exactly one cycle, the cycle in which the last data bit is on `ser_o`.
- R6: Once a frame has been sent, a load request that is not preceded by a clear is ignored: `strb_o` keeps its level and `ser_o` stays 0.
- R7: A load request or clear pulse that arrives while the bit clock runs is ignored. The frame in flight completes unchanged, and the ignored clear does not re-arm the block.
- R8: Frames started by a rising strobe edge and frames started by a falling strobe edge are transmitted identically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bit-clock enable runs on it |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Request to start a frame with `word_i` |
| word_i | input | WORD_W | Parallel word to send |
| clear_i | input | 1 | Re-arm pulse; resets the bit counter when the bit clock is stopped |
| ser_o | output | 1 | Serial data line, LSB first |
| strb_o | output | 1 | Strobe line, changes level once per frame |
| done_o | output | 1 | One-cycle pulse with the last bit of a frame |

## Verification
The hardest situations to reach are the ignored requests. One is a clear and load that land in the middle of a running frame. The other is a load that arrives after a frame without a fresh clear. Both are invisible unless the bench later shows that the strobe did not move and the line stayed quiet. The stimulus therefore injects a combined clear and load on a randomly chosen bit of selected frames. It follows that frame with an uncleared load and watches the outputs for a full frame length. Frames run back to back with random and directed words, so both strobe polarities start frames many times.

// File: rtl/strobe_ser_tx_pkg.sv
package strobe_ser_tx_pkg;
  function automatic int cnt_bits(input int word_w);
    return $clog2(word_w + 1);
  endfunction
endpackage

// File: rtl/strb_edge_ctrl.sv
module strb_edge_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic strb,
  input  logic stop,
  output logic run_en
);
  logic strb_d, stop_d, en_q;
  logic any_edge, stop_rise;

  assign any_edge  = strb ^ strb_d;
  assign stop_rise = stop & ~stop_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_d <= 1'b0;
      stop_d <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      strb_d <= strb;
      stop_d <= stop;
      if (stop_rise)     en_q <= 1'b0;
      else if (any_edge) en_q <= 1'b1;
    end
  end

  assign run_en = en_q;
endmodule

// File: rtl/bit_counter.sv
module bit_counter
  import strobe_ser_tx_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int CW = cnt_bits(WORD_W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  output logic [CW-1:0] cnt,
  output logic          stop
);
  localparam logic [CW-1:0] LAST = CW'(WORD_W);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt  = cnt_q;
  assign stop = (cnt_q == LAST);
endmodule

// File: rtl/piso_shift.sv
module piso_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              tick,
  input  logic [WORD_W-1:0] word,
  output logic              ser
);
  logic [WORD_W-1:0] sh_q;
  logic              ser_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      ser_q <= 1'b0;
    end else begin
      if (load) begin
        sh_q <= word;
      end else if (tick) begin
        sh_q <= {1'b0, sh_q[WORD_W-1:1]};
      end
      ser_q <= tick ? sh_q[0] : 1'b0;
    end
  end

  assign ser = ser_q;
endmodule

// File: rtl/strobe_ser_tx.sv
module strobe_ser_tx
  import strobe_ser_tx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              clear_i,
  output logic              ser_o,
  output logic              strb_o,
  output logic              done_o
);
  localparam int CW = cnt_bits(WORD_W);
  localparam logic [CW-1:0] PENULT = CW'(WORD_W - 1);

  logic          run_en, stop, tick, load_ok, clear_ok;
  logic          armed_q, strb_q, done_q;
  logic [CW-1:0] bit_cnt;

  assign load_ok  = load_i & armed_q & ~run_en;
  assign clear_ok = clear_i & ~run_en;
  assign tick     = run_en & ~stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b1;
      strb_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (load_ok)       armed_q <= 1'b0;
      else if (clear_ok) armed_q <= 1'b1;
      if (load_ok) strb_q <= ~strb_q;
      done_q <= tick && (bit_cnt == PENULT);
    end
  end

  strb_edge_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb_q),
    .stop   (stop),
    .run_en (run_en)
  );

  bit_counter #(.WORD_W(WORD_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (clear_ok | load_ok),
    .tick (tick),
    .cnt  (bit_cnt),
    .stop (stop)
  );

  piso_shift #(.WORD_W(WORD_W)) u_sh (
    .clk  (clk),
    .rst  (rst),
    .load (load_ok),
    .tick (tick),
    .word (word_i),
    .ser  (ser_o)
  );

  assign strb_o = strb_q;
  assign done_o = done_q;
endmodule

// File: rtl/strobe_ser_tx_chk.sv
module strobe_ser_tx_chk
  import strobe_ser_tx_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int CW = cnt_bits(WORD_W)
) (
  input logic          clk,
  input logic          rst,
  input logic          strb_o,
  input logic          ser_o,
  input logic          done_o,
  input logic          run_en,
  input logic [CW-1:0] bit_cnt
);
  a_r2_single_flip: assert property (@(posedge clk) disable iff (rst)
    (strb_o != $past(strb_o)) |=> $stable(strb_o));

  a_r7_no_flip_running: assert property (@(posedge clk) disable iff (rst)
    run_en |=> $stable(strb_o));

  a_r4_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    ser_o |-> $past(run_en));

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r5_done_in_frame: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(run_en));

  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CW'(WORD_W));
endmodule

bind strobe_ser_tx strobe_ser_tx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .strb_o  (strb_o),
  .ser_o   (ser_o),
  .done_o  (done_o),
  .run_en  (run_en),
  .bit_cnt (bit_cnt)
);

// File: tb/tb_strobe_ser_tx.sv
module tb_strobe_ser_tx;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_i = 1'b0;
  logic         clear_i = 1'b0;
  logic [W-1:0] word_i = '0;
  logic         ser_o, strb_o, done_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  ended = 0;

  always #10 clk = ~clk;

  strobe_ser_tx #(.WORD_W(W)) dut (
    .clk(clk), .rst(rst), .load_i(load_i), .word_i(word_i),
    .clear_i(clear_i), .ser_o(ser_o), .strb_o(strb_o), .done_o(done_o)
  );

  function automatic logic exp_bit(input logic [W-1:0] w, input int i);
    return w[i];
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Sends one frame; if poke >= 0 a clear and load are injected on that bit.
  task automatic send(input logic [W-1:0] w, input int poke, input bit do_clear);
    logic s0;
    if (do_clear) begin
      @(negedge clk); clear_i = 1'b1;
    end
    @(negedge clk); clear_i = 1'b0; load_i = 1'b1; word_i = w;
    s0 = strb_o;
    @(negedge clk); load_i = 1'b0; word_i = ~w;
    check(strb_o == ~s0, "R2 strobe flip", strb_o, ~s0);
    check(strb_o != s0, "R8 strobe edge polarity", strb_o, ~s0);
    check(ser_o == 1'b0, "R4 quiet before data", ser_o, 0);
    @(negedge clk);
    check(ser_o == 1'b0, "R4 quiet gap cycle", ser_o, 0);
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      clear_i = 1'b0; load_i = 1'b0;
      check(ser_o == exp_bit(w, i), "R3 data bit", ser_o, exp_bit(w, i));
      check(done_o == (i == W - 1), "R5 done timing", done_o, i == W - 1);
      check(strb_o == ~s0, "R7 strobe held in frame", strb_o, ~s0);
      if (i == poke) begin
        clear_i = 1'b1; load_i = 1'b1; word_i = $urandom;
      end
    end
    @(negedge clk);
    clear_i = 1'b0; load_i = 1'b0;
    check(ser_o == 1'b0, "R4 quiet after data", ser_o, 0);
    check(done_o == 1'b0, "R5 done one cycle", done_o, 0);
  endtask

  task automatic uncleared_load();
    logic s0;
    @(negedge clk); load_i = 1'b1; word_i = 8'hFF;
    s0 = strb_o;
    @(negedge clk); load_i = 1'b0;
    for (int i = 0; i < W + 4; i++) begin
      check(strb_o == s0, "R6 strobe unchanged", strb_o, s0);
      check(ser_o == 1'b0, "R6 line quiet", ser_o, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd1729));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(strb_o == 1'b0, "R1 reset strobe", strb_o, 0);
    check(ser_o == 1'b0, "R1 reset data", ser_o, 0);
    check(done_o == 1'b0, "R1 reset done", done_o, 0);
    // R1: armed after reset, no clear needed
    send(8'hA5, -1, 1'b0);
    send(8'h00, -1, 1'b1);
    send(8'hFF, -1, 1'b1);
    send(8'h01, -1, 1'b1);
    send(8'h80, -1, 1'b1);
    // R7 mid-frame pokes, then R6 uncleared load
    send(8'h3C, 0, 1'b1);
    uncleared_load();
    send(8'hC3, W - 1, 1'b1);
    uncleared_load();
    for (int k = 0; k < 24; k++) begin
      int p;
      p = ($urandom % 3 == 0) ? int'($urandom % W) : -1;
      send(W'($urandom), p, 1'b1);
      if (p >= 0) uncleared_load();
    end
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule